// File: doc/BRIEF.md
# Two-Port Memory with Cross-Port Mailbox Interrupts

This block is a synchronous memory shared by two independent ports, called left and right. Each port has its own enable, write strobe, address and data buses, so the two sides can read or write any word at the same time. Reads are registered. The data for a read appears one clock after the port presents the address, and the read register keeps its value until that port issues its next read.

The two top word locations double as mailboxes, so the two processors can pass messages and signal each other. The top address belongs to the right port and the address one below it belongs to the left port. When a port writes its peer's mailbox, the peer's interrupt flag goes high. The flag drops only when its owner reads its own mailbox.

Each port also has a busy input that comes from a separate contention arbiter. While a port's busy input is high, that port's write has no effect at all, and its read of its own mailbox does not acknowledge the interrupt. The memory depth is two to the power of the address width.

Top module: `xport_mailbox_ram`

## Requirements
- R1: During reset and in the first cycle after it, both interrupt outputs read 0. Both read-data outputs reset to 0.
- R2: A read is a cycle with enable=1 and write=0. Its data appears on that port's read bus at the first clock edge after the address is presented. The read bus holds that value until the same port's next read.
- R3: A write is a cycle with enable=1, write=1 and busy=0. It stores the word, and a later read from either port returns it. A read in the same cycle as a write to that address returns the earlier contents.
- R4: A left-port write to the top address (all ones) sets the right interrupt at the next edge. A right-port write to the top address minus one sets the left interrupt at the next edge.
- R5: The left port reading address top-1 with busy=0 clears the left interrupt at the next edge. The right port reading the top address with busy=0 clears the right interrupt at the next edge.
- R6: A port that reads its peer's mailbox gets the stored word and does not change either interrupt.
- R7: While a port's busy input is 1, its write neither stores data nor sets the peer's interrupt.
- R8: While a port's busy input is 1, its read of its own mailbox still returns the word, but its interrupt stays set.
- R9: If a set and a clear of the same interrupt fall in the same cycle, the interrupt is 1 after the edge.
- R10: A port writing its own mailbox stores the word and leaves both interrupts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| lEn | input | 1 | Left port access enable |
| lWr | input | 1 | Left port write strobe (1 = write, 0 = read) |
| lAddr | input | ADDR_W | Left port word address |
| lWdata | input | DATA_W | Left port write data |
| lBusy | input | 1 | Left port lost contention |
| lRdata | output | DATA_W | Left port registered read data |
| lIrq | output | 1 | Left port mailbox interrupt |
| rEn | input | 1 | Right port access enable |
| rWr | input | 1 | Right port write strobe (1 = write, 0 = read) |
| rAddr | input | ADDR_W | Right port word address |
| rWdata | input | DATA_W | Right port write data |
| rBusy | input | 1 | Right port lost contention |
| rRdata | output | DATA_W | Right port registered read data |
| rIrq | output | 1 | Right port mailbox interrupt |

## Verification
Every result of this block is due exactly one clock edge after the cycle that causes it:
- read data on either bus;
- an interrupt being set by a peer write;
- an interrupt being cleared by an owner read.

The driver applies each cycle's inputs on the falling edge and queues the full expected port state for the following rising edge. The monitor samples one nanosecond after that rising edge and pops exactly one expected entry per driven cycle. Busy-blocked writes are confirmed with a later read through the normal port.

// File: rtl/xmbox_pkg.sv
package xmbox_pkg;
  // port index 0 = left, 1 = right
  localparam int NUM_PORTS = 2;

  typedef struct packed {
    logic [NUM_PORTS-1:0] wrCommit;  // write reaches the array
    logic [NUM_PORTS-1:0] rdFire;    // read register loads
  } xmboxStrobes_t;
endpackage

// File: rtl/xmbox_ctrl.sv
module xmbox_ctrl
  import xmbox_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lEn,
  input  logic              lWr,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lBusy,
  input  logic              rEn,
  input  logic              rWr,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rBusy,
  output xmboxStrobes_t     stb,
  output logic              lIrq,
  output logic              rIrq
);
  localparam logic [ADDR_W-1:0] TOP_ADDR  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] NEXT_ADDR = TOP_ADDR - 1'b1;

  logic              en   [NUM_PORTS];
  logic              wr   [NUM_PORTS];
  logic              busy [NUM_PORTS];
  logic [ADDR_W-1:0] addr [NUM_PORTS];
  logic [NUM_PORTS-1:0] irqSet, irqClr, irqQ;

  assign en[0]   = lEn;   assign en[1]   = rEn;
  assign wr[0]   = lWr;   assign wr[1]   = rWr;
  assign busy[0] = lBusy; assign busy[1] = rBusy;
  assign addr[0] = lAddr; assign addr[1] = rAddr;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] OWN_BOX = (p == 0) ? NEXT_ADDR : TOP_ADDR;
    localparam int PEER = NUM_PORTS - 1 - p;

    always_comb begin
      stb.rdFire[p]   = en[p] & ~wr[p];
      stb.wrCommit[p] = en[p] & wr[p] & ~busy[p];
    end

    // peer write into this port's box sets; owner read (not busy) clears
    assign irqSet[p] = en[PEER] & wr[PEER] & ~busy[PEER] & (addr[PEER] == OWN_BOX);
    assign irqClr[p] = en[p] & ~wr[p] & ~busy[p] & (addr[p] == OWN_BOX);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           irqQ[p] <= 1'b0;
      else if (irqSet[p])  irqQ[p] <= 1'b1;   // set has priority
      else if (irqClr[p])  irqQ[p] <= 1'b0;
    end
  end

  assign lIrq = irqQ[0];
  assign rIrq = irqQ[1];
endmodule

// File: rtl/xmbox_datapath.sv
module xmbox_datapath
  import xmbox_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  xmboxStrobes_t     stb,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWdata,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWdata,
  output logic [DATA_W-1:0] lRdata,
  output logic [DATA_W-1:0] rRdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // same-address collision: left is applied last and is kept
  always_ff @(posedge clk) begin
    if (stb.wrCommit[1]) mem[rAddr] <= rWdata;
    if (stb.wrCommit[0]) mem[lAddr] <= lWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lRdata <= '0;
      rRdata <= '0;
    end else begin
      if (stb.rdFire[0]) lRdata <= mem[lAddr];
      if (stb.rdFire[1]) rRdata <= mem[rAddr];
    end
  end
endmodule

// File: rtl/xport_mailbox_ram.sv
module xport_mailbox_ram
  import xmbox_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lEn,
  input  logic              lWr,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWdata,
  input  logic              lBusy,
  output logic [DATA_W-1:0] lRdata,
  output logic              lIrq,
  input  logic              rEn,
  input  logic              rWr,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWdata,
  input  logic              rBusy,
  output logic [DATA_W-1:0] rRdata,
  output logic              rIrq
);
  xmboxStrobes_t stb;

  xmbox_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .lEn(lEn), .lWr(lWr), .lAddr(lAddr), .lBusy(lBusy),
    .rEn(rEn), .rWr(rWr), .rAddr(rAddr), .rBusy(rBusy),
    .stb(stb), .lIrq(lIrq), .rIrq(rIrq)
  );

  xmbox_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .lAddr(lAddr), .lWdata(lWdata), .rAddr(rAddr), .rWdata(rWdata),
    .lRdata(lRdata), .rRdata(rRdata)
  );
endmodule

// File: rtl/xmbox_checker.sv
module xmbox_checker #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              lEn,
  input logic              lWr,
  input logic [ADDR_W-1:0] lAddr,
  input logic              lBusy,
  input logic              lIrq,
  input logic              rEn,
  input logic              rWr,
  input logic [ADDR_W-1:0] rAddr,
  input logic              rBusy,
  input logic              rIrq
);
  localparam logic [ADDR_W-1:0] TOP_ADDR  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] NEXT_ADDR = TOP_ADDR - 1'b1;

  // R1
  a_r1_irq_reset: assert property (@(posedge clk) !rstN |=> (!lIrq && !rIrq));

  // R4
  a_r4_right_set: assert property (@(posedge clk) disable iff (!rstN)
    (lEn && lWr && !lBusy && lAddr == TOP_ADDR) |=> rIrq);
  a_r4_left_set: assert property (@(posedge clk) disable iff (!rstN)
    (rEn && rWr && !rBusy && rAddr == NEXT_ADDR) |=> lIrq);

  // R5
  a_r5_right_clear: assert property (@(posedge clk) disable iff (!rstN)
    (rEn && !rWr && !rBusy && rAddr == TOP_ADDR &&
     !(lEn && lWr && !lBusy && lAddr == TOP_ADDR)) |=> !rIrq);
  a_r5_left_clear: assert property (@(posedge clk) disable iff (!rstN)
    (lEn && !lWr && !lBusy && lAddr == NEXT_ADDR &&
     !(rEn && rWr && !rBusy && rAddr == NEXT_ADDR)) |=> !lIrq);

  // R7: an interrupt only rises after an unblocked peer write to the box
  a_r7_right_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rIrq) |-> $past(lEn && lWr && !lBusy && lAddr == TOP_ADDR));
  a_r7_left_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lIrq) |-> $past(rEn && rWr && !rBusy && rAddr == NEXT_ADDR));

  // R8: an interrupt only falls after an unblocked owner read
  a_r8_right_fall_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rIrq) |-> $past(rEn && !rWr && !rBusy && rAddr == TOP_ADDR));
  a_r8_left_fall_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lIrq) |-> $past(lEn && !lWr && !lBusy && lAddr == NEXT_ADDR));
endmodule

bind xport_mailbox_ram xmbox_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN),
  .lEn(lEn), .lWr(lWr), .lAddr(lAddr), .lBusy(lBusy), .lIrq(lIrq),
  .rEn(rEn), .rWr(rWr), .rAddr(rAddr), .rBusy(rBusy), .rIrq(rIrq)
);

// File: tb/xport_mailbox_ram_tb_top.sv
`timescale 1ns/1ps
module xport_mailbox_ram_tb_top;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam logic [AW-1:0] TOP  = {AW{1'b1}};
  localparam logic [AW-1:0] NEXT = TOP - 1'b1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lEn = 0, lWr = 0, lBusy = 0, rEn = 0, rWr = 0, rBusy = 0;
  logic [AW-1:0] lAddr = '0, rAddr = '0;
  logic [DW-1:0] lWdata = '0, rWdata = '0;
  logic [DW-1:0] lRdata, rRdata;
  logic lIrq, rIrq;

  always #2.5 clk = ~clk;

  xport_mailbox_ram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN),
    .lEn(lEn), .lWr(lWr), .lAddr(lAddr), .lWdata(lWdata), .lBusy(lBusy),
    .lRdata(lRdata), .lIrq(lIrq),
    .rEn(rEn), .rWr(rWr), .rAddr(rAddr), .rWdata(rWdata), .rBusy(rBusy),
    .rRdata(rRdata), .rIrq(rIrq)
  );

  typedef struct {
    string         req;
    logic [DW-1:0] lRd;
    logic [DW-1:0] rRd;
    logic          lIq;
    logic          rIq;
  } expItem_t;

  expItem_t expQ[$];
  int nTests = 0;
  int nFail  = 0;
  bit finished = 0;

  // independent model built from the requirements
  logic [DW-1:0] mdlMem [1 << AW];
  logic [DW-1:0] mdlLRd = '0, mdlRRd = '0;
  logic mdlLIrq = 0, mdlRIrq = 0;

  task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic le, lw, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                      input logic lb,
                      input logic re, rw, input logic [AW-1:0] ra, input logic [DW-1:0] rd,
                      input logic rb, input string req);
    expItem_t e;
    logic lRead, rRead, lCom, rCom, lSet, lClr, rSet, rClr;
    @(negedge clk);
    lEn = le; lWr = lw; lAddr = la; lWdata = ld; lBusy = lb;
    rEn = re; rWr = rw; rAddr = ra; rWdata = rd; rBusy = rb;
    lRead = le && !lw;  rRead = re && !rw;
    lCom  = le && lw && !lb;  rCom = re && rw && !rb;
    if (lRead) mdlLRd = mdlMem[la];
    if (rRead) mdlRRd = mdlMem[ra];
    rSet = lCom && la == TOP;   rClr = rRead && !rb && ra == TOP;
    lSet = rCom && ra == NEXT;  lClr = lRead && !lb && la == NEXT;
    if (rSet) mdlRIrq = 1; else if (rClr) mdlRIrq = 0;
    if (lSet) mdlLIrq = 1; else if (lClr) mdlLIrq = 0;
    if (rCom) mdlMem[ra] = rd;
    if (lCom) mdlMem[la] = ld;
    e.req = req; e.lRd = mdlLRd; e.rRd = mdlRRd; e.lIq = mdlLIrq; e.rIq = mdlRIrq;
    expQ.push_back(e);
  endtask

  task automatic idle(input string req);
    step(0, 0, '0, '0, 0, 0, 0, '0, '0, 0, req);
  endtask

  // monitor: one expected entry per driven cycle, sampled after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        check(e.req, "lRdata", lRdata, e.lRd);
        check(e.req, "rRdata", rRdata, e.rRd);
        check(e.req, "lIrq", {{(DW-1){1'b0}}, lIrq}, {{(DW-1){1'b0}}, e.lIq});
        check(e.req, "rIrq", {{(DW-1){1'b0}}, rIrq}, {{(DW-1){1'b0}}, e.rIq});
      end
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "lIrq in reset", {15'b0, lIrq}, 16'h0);
    check("R1", "rRdata in reset", rRdata, 16'h0);
    @(negedge clk);
    rstN = 1'b1;
    idle("R1");
    // R3: plain writes on both ports, then cross reads
    step(1, 1, 6'd5, 16'h1234, 0, 1, 1, 6'd9, 16'hABCD, 0, "R3");
    step(1, 0, 6'd9, '0, 0, 1, 0, 6'd5, '0, 0, "R3");
    // R2: read buses hold when idle
    idle("R2");
    // R3: read during write to same address returns old word
    step(1, 1, 6'd5, 16'h5555, 0, 1, 0, 6'd5, '0, 0, "R3");
    step(0, 0, '0, '0, 0, 1, 0, 6'd5, '0, 0, "R2");
    // R4: both mailboxes written by the peers
    step(1, 1, TOP, 16'h0063, 0, 1, 1, NEXT, 16'h0062, 0, "R4");
    // R6: peer reads leave interrupts alone
    step(1, 0, TOP, '0, 0, 1, 0, NEXT, '0, 0, "R6");
    // R8: busy owner read keeps the interrupt but returns data
    step(1, 0, NEXT, '0, 1, 1, 0, TOP, '0, 1, "R8");
    // R5: unblocked owner reads clear
    step(1, 0, NEXT, '0, 0, 1, 0, TOP, '0, 0, "R5");
    // R7: busy writes neither store nor interrupt
    step(1, 1, TOP, 16'h7777, 1, 1, 1, 6'd9, 16'h9999, 1, "R7");
    step(1, 0, 6'd9, '0, 0, 1, 0, TOP, '0, 0, "R7");
    step(1, 1, 6'd9, 16'h4444, 0, 1, 1, NEXT, 16'h8888, 1, "R7");
    step(1, 0, NEXT, '0, 0, 1, 0, 6'd9, '0, 0, "R7");
    // R9: set and clear of the right interrupt together
    step(1, 1, TOP, 16'h00AA, 0, 1, 0, TOP, '0, 0, "R9");
    step(0, 0, '0, '0, 0, 1, 0, TOP, '0, 0, "R9");
    step(1, 1, NEXT, 16'h0B0B, 0, 0, 0, '0, '0, 0, "R4");
    step(1, 0, NEXT, '0, 0, 1, 1, NEXT, 16'h0C0C, 0, "R9");
    // R10: own-mailbox writes do not touch the interrupts
    step(1, 1, NEXT, 16'h0D0D, 0, 1, 1, TOP, 16'h0E0E, 0, "R10");
    step(1, 0, TOP, '0, 1, 1, 0, NEXT, '0, 1, "R10");
    idle("R2");
    repeat (3) @(posedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule